// File: doc/BRIEF.md
# Integer Execute Unit for a 32-bit RISC-V Base Core

This block is the arithmetic and logic step of a 32-bit integer pipeline. Each cycle it receives an instruction that has already been decoded into a class (register-register, register-immediate, load-upper-immediate or add-upper-immediate-to-PC), along with the funct3 and funct7 fields, the two source register values, the raw instruction word and the PC of that instruction. It selects the operation, forms the immediate, and computes the 32-bit value for write-back. It also flags encodings whose funct7 field is not legal for the given funct3.

The outputs sit in one stage register with an asynchronous active-low reset. A result therefore appears one rising clock edge after its inputs are presented. Memory access, branches, the register file and hazard handling belong to neighbouring blocks.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, `result` and `illegal` are 0.
- R2: The `op_class` encoding is 0 = register-register, 1 = register-immediate, 2 = load upper immediate, 3 = add upper immediate to PC. Outputs for a set of inputs appear after the next rising clock edge, and they hold until that edge.
- R3: funct3 000 adds with wrap modulo 2^32. In the register form, funct7 0000000 adds and funct7 0100000 computes rs1 minus rs2. The immediate form always adds, so there is no subtract-immediate.
- R4: In the immediate form, the operand is instruction bits 31:20 sign-extended to 32 bits. This applies to add (000), set-less-than (010, 011), XOR (100), OR (110) and AND (111).
- R5: funct3 010 compares as signed and funct3 011 compares as unsigned, and either one returns exactly 1 or 0. The unsigned immediate compare uses the sign-extended immediate read as unsigned, so an immediate of 1 gives 1 only when rs1 is zero.
- R6: funct3 100, 110 and 111 give bitwise XOR, OR and AND. An XOR with immediate -1 gives the bitwise inverse of rs1.
- R7: funct3 001 shifts left logically. The shift amount is rs2 bits 4:0 in the register form and instruction bits 24:20 in the immediate form. Higher bits of rs2 are ignored.
- R8: funct3 101 shifts right. funct7 0000000 (instruction bit 30 clear) fills the vacated bits with zeros. funct7 0100000 (bit 30 set) fills them with the sign bit.
- R9: Class 2 returns instruction bits 31:12 in result bits 31:12, with bits 11:0 zero.
- R10: Class 3 returns the PC plus the same upper-immediate value, wrapping modulo 2^32.
- R11: A funct7 outside the legal set sets `illegal` to 1 and forces `result` to 0. The legal set for the register form is 0000000 for every funct3, plus 0100000 for 000 and 101. The legal set for immediate shifts is 0000000 for 001, and 0000000 or 0100000 for 101.
- R12: A no-operation (immediate add with rs1 value 0 and immediate 0) gives result 0 with `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 2 | Decoded instruction class |
| funct3 | input | 3 | Operation field |
| funct7 | input | 7 | Operation modifier field |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| instr | input | 32 | Raw instruction word for immediate extraction |
| pc | input | 32 | Address of the instruction |
| result | output | 32 | Registered write-back value |
| illegal | output | 1 | Registered illegal-encoding flag |

## Verification
A wrong decode state shows up at `result` on the very next edge. Typical symptoms are a swapped right-shift fill, a subtract where an add was due, or a missing sign extension. Because every input maps to exactly one registered output, a single vector exposes a fault after one cycle. The sweeps therefore pair every class, funct3 and a spread of funct7 values with corner operands such as zero, all ones, the sign bit alone, and shift amounts at 0 and 31. A stale or missing register stage shows as the previous vector's value when the output is sampled before the edge.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [1:0] {
        CLS_REG   = 2'd0,
        CLS_IMM   = 2'd1,
        CLS_LUI   = 2'd2,
        CLS_AUIPC = 2'd3
    } op_class_e;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLL,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_SRL,
        ALU_SRA,
        ALU_OR,
        ALU_AND,
        ALU_PASS_B
    } alu_op_e;

    typedef enum logic [1:0] {
        BSEL_RS2,
        BSEL_IMM_I,
        BSEL_IMM_U
    } b_sel_e;

    typedef struct packed {
        alu_op_e op;
        b_sel_e  b_sel;
        logic    a_is_pc;
        logic    illegal;
    } dec_t;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_SLL  = 3'b001;
    localparam logic [2:0] F3_SLT  = 3'b010;
    localparam logic [2:0] F3_SLTU = 3'b011;
    localparam logic [2:0] F3_XOR  = 3'b100;
    localparam logic [2:0] F3_SR   = 3'b101;
    localparam logic [2:0] F3_OR   = 3'b110;
    localparam logic [2:0] F3_AND  = 3'b111;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [1:0] op_class,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output dec_t       dec
);

    function automatic alu_op_e plain_op(input logic [2:0] f3);
        alu_op_e o;
        case (f3)
            F3_ADD:  o = ALU_ADD;
            F3_SLL:  o = ALU_SLL;
            F3_SLT:  o = ALU_SLT;
            F3_SLTU: o = ALU_SLTU;
            F3_XOR:  o = ALU_XOR;
            F3_SR:   o = ALU_SRL;
            F3_OR:   o = ALU_OR;
            default: o = ALU_AND;
        endcase
        return o;
    endfunction

    always_comb begin
        dec.op      = ALU_ADD;
        dec.b_sel   = BSEL_RS2;
        dec.a_is_pc = 1'b0;
        dec.illegal = 1'b0;
        case (op_class_e'(op_class))
            CLS_REG: begin
                dec.op = plain_op(funct3);
                if (funct7 == F7_ALT && funct3 == F3_ADD) begin
                    dec.op = ALU_SUB;
                end else if (funct7 == F7_ALT && funct3 == F3_SR) begin
                    dec.op = ALU_SRA;
                end else if (funct7 != F7_BASE) begin
                    dec.illegal = 1'b1;
                end
            end
            CLS_IMM: begin
                dec.b_sel = BSEL_IMM_I;
                dec.op    = plain_op(funct3);
                if (funct3 == F3_SLL) begin
                    dec.illegal = (funct7 != F7_BASE);
                end else if (funct3 == F3_SR) begin
                    if (funct7 == F7_ALT) begin
                        dec.op = ALU_SRA;
                    end else if (funct7 != F7_BASE) begin
                        dec.illegal = 1'b1;
                    end
                end
            end
            CLS_LUI: begin
                dec.b_sel = BSEL_IMM_U;
                dec.op    = ALU_PASS_B;
            end
            default: begin
                dec.b_sel   = BSEL_IMM_U;
                dec.a_is_pc = 1'b1;
                dec.op      = ALU_ADD;
            end
        endcase
    end

endmodule

// File: rtl/exu_operands.sv
module exu_operands
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 32
) (
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] pc,
    input  logic [ILEN-1:0] instr,
    input  dec_t            dec,
    output logic [XLEN-1:0] op_a,
    output logic [XLEN-1:0] op_b
);

    localparam int IMM_I_W = 12;
    localparam int IMM_U_W = 20;
    localparam int U_LOW_W = ILEN - IMM_U_W;

    logic signed [IMM_I_W-1:0] imm_i_raw;
    logic signed [ILEN-1:0]    imm_u_raw;
    logic [XLEN-1:0]           imm_i;
    logic [XLEN-1:0]           imm_u;

    always_comb begin
        imm_i_raw = instr[ILEN-1 -: IMM_I_W];
        imm_u_raw = {instr[ILEN-1 -: IMM_U_W], {U_LOW_W{1'b0}}};
        imm_i     = XLEN'(imm_i_raw);
        imm_u     = XLEN'(imm_u_raw);
        op_a      = dec.a_is_pc ? pc : rs1_val;
        case (dec.b_sel)
            BSEL_IMM_I: op_b = imm_i;
            BSEL_IMM_U: op_b = imm_u;
            default:    op_b = rs2_val;
        endcase
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);

    localparam int SHAMT_W = $clog2(XLEN);

    logic [SHAMT_W-1:0] shamt;
    logic               lt_s;
    logic               lt_u;

    always_comb begin
        shamt = op_b[SHAMT_W-1:0];
        lt_s  = $signed(op_a) < $signed(op_b);
        lt_u  = op_a < op_b;
        case (op)
            ALU_ADD:    y = op_a + op_b;
            ALU_SUB:    y = op_a - op_b;
            ALU_SLL:    y = op_a << shamt;
            ALU_SLT:    y = XLEN'(lt_s);
            ALU_SLTU:   y = XLEN'(lt_u);
            ALU_XOR:    y = op_a ^ op_b;
            ALU_SRL:    y = op_a >> shamt;
            ALU_SRA:    y = XLEN'($signed(op_a) >>> shamt);
            ALU_OR:     y = op_a | op_b;
            ALU_AND:    y = op_a & op_b;
            ALU_PASS_B: y = op_b;
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      op_class,
    input  logic [2:0]      funct3,
    input  logic [6:0]      funct7,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] result,
    output logic            illegal
);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            illegal;
    } stage_t;

    dec_t            dec;
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [XLEN-1:0] alu_y;
    stage_t          st_d;
    stage_t          st_q;

    exu_decode u_dec (
        .op_class (op_class),
        .funct3   (funct3),
        .funct7   (funct7),
        .dec      (dec)
    );

    exu_operands #(.XLEN(XLEN), .ILEN(ILEN)) u_opnd (
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .pc      (pc),
        .instr   (instr),
        .dec     (dec),
        .op_a    (op_a),
        .op_b    (op_b)
    );

    exu_alu #(.XLEN(XLEN)) u_alu (
        .op_a (op_a),
        .op_b (op_b),
        .op   (dec.op),
        .y    (alu_y)
    );

    always_comb begin
        st_d.illegal = dec.illegal;
        st_d.result  = dec.illegal ? '0 : alu_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.result;
    assign illegal = st_q.illegal;

endmodule

// File: rtl/exu_chk.sv
module exu_chk #(
    parameter int XLEN = 32,
    parameter int ILEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      op_class,
    input logic [2:0]      funct3,
    input logic [6:0]      funct7,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [ILEN-1:0] instr,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] result,
    input logic            illegal
);

    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (result == '0 && illegal == 1'b0);
        end
    end

    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> result == '0);

    assert_lui_low_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_class == 2'd2) |-> (result[11:0] == 12'h000 && !illegal));

    assert_cmp_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past((op_class == 2'd1 || (op_class == 2'd0 && funct7 == 7'd0)) &&
              (funct3 == 3'b010 || funct3 == 3'b011))
        |-> result[XLEN-1:1] == '0);

    assert_auipc_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_class == 2'd3 && instr[31:12] == 20'd0) |-> result == $past(pc));

    assert_add_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_class == 2'd0 && funct3 == 3'b000 && funct7 == 7'd0 && rs2_val == '0)
        |-> result == $past(rs1_val));

    assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_class == 2'd1 && funct3 == 3'b000 && instr[31:20] == 12'd0 && rs1_val == '0)
        |-> (result == '0 && !illegal));

endmodule

bind int_exec_unit exu_chk #(.XLEN(XLEN), .ILEN(ILEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_class (op_class),
    .funct3   (funct3),
    .funct7   (funct7),
    .rs1_val  (rs1_val),
    .rs2_val  (rs2_val),
    .instr    (instr),
    .pc       (pc),
    .result   (result),
    .illegal  (illegal)
);

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [2:0]  funct3 = 3'd0;
    logic [6:0]  funct7 = 7'd0;
    logic [31:0] rs1_val = 32'h1234_5678;
    logic [31:0] rs2_val = 32'h0000_0011;
    logic [31:0] instr = 32'hDEAD_BEEF;
    logic [31:0] pc = 32'h0000_1000;
    logic [31:0] result;
    logic        illegal;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] lfsr = 32'hACE1_2345;

    always #4 clk = ~clk;

    int_exec_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_class (op_class),
        .funct3   (funct3),
        .funct7   (funct7),
        .rs1_val  (rs1_val),
        .rs2_val  (rs2_val),
        .instr    (instr),
        .pc       (pc),
        .result   (result),
        .illegal  (illegal)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Reference: returns {illegal, result}
    function automatic logic [32:0] ref_exec(input logic [1:0] c, input logic [2:0] f3,
                                             input logic [6:0] f7, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] ins,
                                             input logic [31:0] p);
        logic [31:0] opb;
        logic [31:0] up;
        logic [4:0]  sh;
        logic        bad;
        logic [31:0] r;
        up  = {ins[31:12], 12'h000};
        bad = 1'b0;
        r   = 32'h0;
        if (c == 2'd2) return {1'b0, up};
        if (c == 2'd3) return {1'b0, p + up};
        opb = (c == 2'd0) ? b : {{20{ins[31]}}, ins[31:20]};
        sh  = (c == 2'd0) ? b[4:0] : ins[24:20];
        case (f3)
            3'd0: begin
                if (c == 2'd0 && f7 == 7'h20) r = a + ~opb + 32'd1;
                else begin r = a + opb; bad = (c == 2'd0 && f7 != 7'h00); end
            end
            3'd1: begin r = a << sh; bad = (f7 != 7'h00); end
            3'd2: begin
                r = ((a ^ 32'h8000_0000) < (opb ^ 32'h8000_0000)) ? 32'd1 : 32'd0;
                bad = (c == 2'd0 && f7 != 7'h00);
            end
            3'd3: begin r = (a < opb) ? 32'd1 : 32'd0; bad = (c == 2'd0 && f7 != 7'h00); end
            3'd4: begin r = a ^ opb; bad = (c == 2'd0 && f7 != 7'h00); end
            3'd5: begin
                r = a >> sh;
                if (f7 == 7'h20) r = r | (a[31] ? ~(32'hFFFF_FFFF >> sh) : 32'h0);
                else bad = (f7 != 7'h00);
            end
            3'd6: begin r = a | opb; bad = (c == 2'd0 && f7 != 7'h00); end
            default: begin r = a & opb; bad = (c == 2'd0 && f7 != 7'h00); end
        endcase
        if (bad) r = 32'h0;
        return {bad, r};
    endfunction

    function automatic string tag_of(input logic [1:0] c, input logic [2:0] f3, input logic bad);
        if (bad) return "R11";
        if (c == 2'd2) return "R9";
        if (c == 2'd3) return "R10";
        case (f3)
            3'd0: return "R3";
            3'd1: return "R7";
            3'd2, 3'd3: return "R5";
            3'd5: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got illegal=%0b result=%08h, expected illegal=%0b result=%08h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [2:0] f3, input logic [6:0] f7,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] ins, input logic [31:0] p);
        @(negedge clk);
        op_class = c; funct3 = f3; funct7 = f7;
        rs1_val = a; rs2_val = b; instr = ins; pc = p;
    endtask

    task automatic apply(input string tag, input logic [1:0] c, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] ins, input logic [31:0] p);
        logic [32:0] exp;
        drive(c, ins[14:12], ins[31:25], a, b, ins, p);
        exp = ref_exec(c, ins[14:12], ins[31:25], a, b, ins, p);
        @(posedge clk);
        #2;
        if (tag == "") check(tag_of(c, ins[14:12], exp[32]), {illegal, result}, exp);
        else check(tag, {illegal, result}, exp);
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] f5,
                                       input logic [2:0] f3);
        return {f7, f5, 5'd3, f3, 5'd7, 7'h13};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] corners [8];
        logic [6:0]  f7s [4];
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                    32'h7FFF_FFFF, 32'h0000_001F, 32'h0000_0020, 32'h1234_5678};
        f7s = '{7'h00, 7'h20, 7'h01, 7'h40};

        repeat (3) @(posedge clk);
        #2;
        check("R1", {illegal, result}, 33'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: latency of one edge
        apply("R2", 2'd0, 32'd1, 32'd1, mk(7'h00, 5'd0, 3'd0), 32'h0);
        drive(2'd0, 3'd0, 7'h00, 32'd5, 32'd5, mk(7'h00, 5'd0, 3'd0), 32'h0);
        #1;
        check("R2", {illegal, result}, {1'b0, 32'd2});
        @(posedge clk);
        #2;
        check("R2", {illegal, result}, {1'b0, 32'd10});

        // Directed corner cases
        apply("R3", 2'd0, 32'd0, 32'd1, mk(7'h20, 5'd0, 3'd0), 32'h0);
        check("R3", {illegal, result}, {1'b0, 32'hFFFF_FFFF});
        apply("R3", 2'd0, 32'hFFFF_FFFF, 32'd1, mk(7'h00, 5'd0, 3'd0), 32'h0);
        check("R3", {illegal, result}, {1'b0, 32'h0});
        apply("R4", 2'd1, 32'd100, 32'd0, {12'hFFF, 5'd3, 3'd0, 5'd7, 7'h13}, 32'h0);
        check("R4", {illegal, result}, {1'b0, 32'd99});
        apply("R4", 2'd1, 32'h0000_0F0F, 32'd0, {12'h800, 5'd3, 3'd7, 5'd7, 7'h13}, 32'h0);
        check("R4", {illegal, result}, {1'b0, 32'h0000_0800});
        apply("R5", 2'd1, 32'd0, 32'd0, {12'h001, 5'd3, 3'd3, 5'd7, 7'h13}, 32'h0);
        check("R5", {illegal, result}, {1'b0, 32'd1});
        apply("R5", 2'd1, 32'd7, 32'd0, {12'h001, 5'd3, 3'd3, 5'd7, 7'h13}, 32'h0);
        check("R5", {illegal, result}, {1'b0, 32'd0});
        apply("R5", 2'd0, 32'hFFFF_FFFF, 32'd1, mk(7'h00, 5'd0, 3'd2), 32'h0);
        check("R5", {illegal, result}, {1'b0, 32'd1});
        apply("R6", 2'd1, 32'h1234_5678, 32'd0, {12'hFFF, 5'd3, 3'd4, 5'd7, 7'h13}, 32'h0);
        check("R6", {illegal, result}, {1'b0, 32'hEDCB_A987});
        apply("R7", 2'd1, 32'd13, 32'd0, mk(7'h00, 5'd2, 3'd1), 32'h0);
        check("R7", {illegal, result}, {1'b0, 32'd52});
        apply("R7", 2'd0, 32'd1, 32'hFFFF_FFE4, mk(7'h00, 5'd0, 3'd1), 32'h0);
        check("R7", {illegal, result}, {1'b0, 32'h0000_0010});
        apply("R8", 2'd1, 32'hFFFF_FFF0, 32'd0, mk(7'h20, 5'd2, 3'd5), 32'h0);
        check("R8", {illegal, result}, {1'b0, 32'hFFFF_FFFC});
        apply("R8", 2'd1, 32'hF000_0000, 32'd0, mk(7'h00, 5'd4, 3'd5), 32'h0);
        check("R8", {illegal, result}, {1'b0, 32'h0F00_0000});
        apply("R9", 2'd2, 32'hFFFF_FFFF, 32'd0, 32'hABCDE_FFF, 32'h0);
        check("R9", {illegal, result}, {1'b0, 32'hABCD_E000});
        apply("R10", 2'd3, 32'd0, 32'd0, 32'hFFFFF_037, 32'h0000_0800);
        check("R10", {illegal, result}, {1'b0, 32'hFFFF_F800});
        apply("R11", 2'd0, 32'd3, 32'd4, mk(7'h01, 5'd0, 3'd0), 32'h0);
        check("R11", {illegal, result}, {1'b1, 32'h0});
        apply("R11", 2'd1, 32'd3, 32'd0, mk(7'h20, 5'd1, 3'd1), 32'h0);
        check("R11", {illegal, result}, {1'b1, 32'h0});
        apply("R12", 2'd1, 32'd0, 32'd0, 32'h0000_0013, 32'h0);
        check("R12", {illegal, result}, {1'b0, 32'h0});

        // Near-exhaustive sweep
        for (int c = 0; c < 4; c++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int i = 0; i < 8; i++) begin
                        for (int j = 0; j < 8; j++) begin
                            lfsr = next_rand(lfsr);
                            apply("", 2'(c), corners[i], corners[j],
                                  {f7s[k], corners[j][4:0] ^ lfsr[4:0], lfsr[19:15],
                                   3'(f3), lfsr[11:7], 7'h13},
                                  lfsr ^ 32'h5A5A_0000);
                        end
                    end
                end
            end
        end

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            logic [31:0] b;
            logic [31:0] w;
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b = lfsr;
            lfsr = next_rand(lfsr); w = lfsr;
            lfsr = next_rand(lfsr);
            apply("", lfsr[1:0], a, b, w, lfsr);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule